// File: doc/BRIEF.md
# HDLC Bit-Serial Transmitter with Preamble

This block turns a stream of frame bytes into a bit-serial HDLC line signal. While no frame is pending it sends continuous flag octets (0x7E) as interframe fill. When a frame is offered, it can first send an optional 8-bit preamble pattern a configurable number of times. It then sends an opening flag, the payload with zero-bit insertion, a 16-bit frame check sequence and a closing flag. Bytes arrive on a valid/ready interface. The block emits one line bit for each cycle in which the bit clock enable is high.

The preamble is sent only when the frame is preceded by fill. It goes out verbatim, with no zero insertion. When the next frame is offered before the closing flag has finished, the closing flag is followed straight away by the next opening flag, and no preamble is sent. If no byte is offered when a payload byte is due, the frame is ended at that point. The enable, code and pattern inputs are taken as static while a frame is in progress.

Top module: `hdlc_pre_tx`

## Requirements
- R1: During and directly after reset, `tx_bit` is 1, `tx_eof` is 0 and `in_ready` is 0. The first bits sent after reset belong to a fill flag.
- R2: While no frame is in progress, the line carries back-to-back 0x7E octets, least significant bit first.
- R3: A frame starts only at an octet boundary, and only if `in_valid` is high on the bit enable that completes the current octet. The frame body starts with one opening flag 0x7E.
- R4: When `cfg_pre_en` is 1 and the octet just completed was a fill flag, `cfg_pre_pat` is sent LSB first before the opening flag. It is sent 1, 2, 4 or 8 times for `cfg_rep_code` values 0, 1, 2 and 3.
- R5: No zero is inserted into preamble bits. A pattern of 0xFF repeated eight times appears as 64 consecutive ones.
- R6: If `in_valid` is high when the closing flag completes, the next octet is the opening flag of the next frame. No fill and no preamble are sent in between, even with `cfg_pre_en` set.
- R7: In the payload and the FCS, a 0 is inserted after every run of five consecutive 1s. This includes runs that cross octet boundaries and a run that ends the FCS just before the closing flag. Flags and preamble are never stuffed.
- R8: The FCS is the ones' complement of the CRC over the payload bits in line order. The CRC uses polynomial x^16+x^12+x^5+1, preset 0xFFFF, processed LSB first. The FCS is sent low byte first, each byte LSB first.
- R9: `in_ready` is high for exactly one bit-enable cycle per payload byte. This is the cycle that completes the previous octet. `in_ready` is never high on two consecutive cycles. A byte accepted with `in_last` high is the final payload byte.
- R10: `tx_eof` is 1 exactly while `tx_bit` carries the last bit (a 0) of a closing flag, and 0 otherwise.
- R11: In a cycle where `bit_en` is 0, `tx_bit` and `tx_eof` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit clock enable: one line bit per high cycle |
| cfg_pre_en | input | 1 | Preamble enable |
| cfg_pre_pat | input | 8 | Preamble pattern |
| cfg_rep_code | input | 2 | Preamble repetition code (1 << code repetitions) |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte is the last of its frame |
| in_ready | output | 1 | Payload byte accepted this cycle |
| tx_bit | output | 1 | Serial line bit |
| tx_eof | output | 1 | Marks the final bit of a closing flag |

## Verification
Some properties are checked on every cycle: the outputs hold while the bit enable is low, and the ones-run counter never passes the stuffing limit. A marked end bit is always a zero. Byte acceptances are never adjacent and happen only when the sequencer is heading into payload. Other behaviour can only be shown by the bench's scenarios, which compare every line bit against a stream built from the requirements. These include:
- the number of preamble repetitions and that they are not stuffed;
- the choice between preamble and a shared flag run between back-to-back frames;
- stuffing across octet and FCS boundaries;
- the FCS value.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int BYTE_W = 8;
  localparam int FCS_W  = 16;

  localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;
  // reflected form of x^16 + x^12 + x^5 + 1
  localparam logic [FCS_W-1:0]  FCS_POLY_R = 16'h8408;
  localparam logic [FCS_W-1:0]  FCS_SEED   = 16'hFFFF;

  // kind of octet currently loaded into the serializer
  typedef enum logic [2:0] {
    CH_FILL   = 3'd0,
    CH_PRE    = 3'd1,
    CH_OPEN   = 3'd2,
    CH_DATA   = 3'd3,
    CH_FCS_LO = 3'd4,
    CH_FCS_HI = 3'd5,
    CH_CLOSE  = 3'd6
  } chunk_e;

endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen #(
  parameter int             W      = 16,
  parameter int             DW     = 8,
  parameter logic [W-1:0]   POLY   = 16'h8408,
  parameter logic [W-1:0]   PRESET = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [W-1:0]  crc
);

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;

  // one octet through the reflected LFSR, bit 0 first
  function automatic logic [W-1:0] octet_step(input logic [W-1:0] c_in,
                                              input logic [DW-1:0] d);
    logic [W-1:0] c;
    logic         fb;
    c = c_in;
    for (int i = 0; i < DW; i++) begin
      fb = d[i] ^ c[0];
      c  = c >> 1;
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  always_comb begin
    crc_d = crc_q;
    if (init)     crc_d = PRESET;
    else if (upd) crc_d = octet_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= PRESET;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
  import hdlc_tx_pkg::*;
#(
  parameter int REP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cfg_pre_en,
  input  logic [BYTE_W-1:0] cfg_pre_pat,
  input  logic [REP_W-1:0]  cfg_rep_code,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic [FCS_W-1:0]  fcs_crc,
  output logic [BYTE_W-1:0] ld_byte,
  output logic              ld_stuff,
  output logic              ld_eof,
  output logic              take,
  output logic              crc_init
);

  localparam int CNT_W = (1 << REP_W) - 1;

  chunk_e           st_q, kind;
  logic [CNT_W-1:0] rep_q, rep_d, rep_init;
  logic [CNT_W:0]   reps_full;
  logic             last_q, last_d;

  // repetitions minus one, taken when a preamble run starts
  always_comb begin
    reps_full = (CNT_W+1)'(1) << cfg_rep_code;
    rep_init  = reps_full[CNT_W-1:0] - CNT_W'(1);
  end

  // kind of the octet that follows the one now in the serializer
  always_comb begin
    case (st_q)
      CH_FILL, CH_CLOSE: begin
        if (!in_valid)                          kind = CH_FILL;
        else if (cfg_pre_en && st_q == CH_FILL) kind = CH_PRE;
        else                                    kind = CH_OPEN;
      end
      CH_PRE:    kind = (rep_q != '0) ? CH_PRE : CH_OPEN;
      CH_OPEN:   kind = in_valid ? CH_DATA : CH_FCS_LO;
      CH_DATA:   kind = (last_q || !in_valid) ? CH_FCS_LO : CH_DATA;
      CH_FCS_LO: kind = CH_FCS_HI;
      CH_FCS_HI: kind = CH_CLOSE;
      default:   kind = CH_FILL;
    endcase
  end

  always_comb begin
    rep_d  = rep_q;
    last_d = last_q;
    if (kind == CH_PRE)  rep_d  = (st_q == CH_PRE) ? rep_q - CNT_W'(1) : rep_init;
    if (kind == CH_OPEN) last_d = 1'b0;
    if (kind == CH_DATA) last_d = in_last;
  end

  always_comb begin
    case (kind)
      CH_PRE:    ld_byte = cfg_pre_pat;
      CH_DATA:   ld_byte = in_data;
      CH_FCS_LO: ld_byte = ~fcs_crc[BYTE_W-1:0];
      CH_FCS_HI: ld_byte = ~fcs_crc[FCS_W-1:BYTE_W];
      default:   ld_byte = FLAG_OCTET;
    endcase
    ld_stuff = (kind == CH_DATA) || (kind == CH_FCS_LO) || (kind == CH_FCS_HI);
    ld_eof   = (kind == CH_CLOSE);
    take     = load && (kind == CH_DATA);
    crc_init = load && (kind == CH_OPEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_FILL;
      rep_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      st_q   <= kind;
      rep_q  <= rep_d;
      last_q <= last_d;
    end
  end

  // R9
  take_in_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (st_q == CH_OPEN || st_q == CH_DATA));

  // R8
  fcs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && st_q == CH_FCS_LO) |=> (st_q == CH_FCS_HI));

endmodule

// File: rtl/hdlc_bit_ser.sv
module hdlc_bit_ser
  import hdlc_tx_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              ld_stuff,
  input  logic              ld_eof,
  output logic              load,
  output logic              tx_bit,
  output logic              tx_eof
);

  localparam int IDX_W = $clog2(BYTE_W);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [RUN_W-1:0]  ones_q, ones_d;
  logic              stf_q, stf_d;
  logic              eofc_q, eofc_d;
  logic              bit_q, bit_d;
  logic              eof_q, eof_d;
  logic              ins_zero;
  logic              at_last;

  always_comb begin
    ins_zero = (ones_q == RUN_W'(RUN_LEN));
    at_last  = (idx_q == IDX_W'(BYTE_W - 1));
    load     = bit_en && !ins_zero && at_last;
  end

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    ones_d = ones_q;
    stf_d  = stf_q;
    eofc_d = eofc_q;
    bit_d  = bit_q;
    eof_d  = eof_q;
    if (bit_en) begin
      if (ins_zero) begin
        bit_d  = 1'b0;
        eof_d  = 1'b0;
        ones_d = '0;
      end else begin
        bit_d  = sh_q[0];
        eof_d  = eofc_q && at_last;
        ones_d = (stf_q && sh_q[0]) ? ones_q + RUN_W'(1) : '0;
        if (at_last) begin
          sh_d   = ld_byte;
          idx_d  = '0;
          stf_d  = ld_stuff;
          eofc_d = ld_eof;
        end else begin
          sh_d   = sh_q >> 1;
          idx_d  = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= FLAG_OCTET;
      idx_q  <= '0;
      ones_q <= '0;
      stf_q  <= 1'b0;
      eofc_q <= 1'b0;
      bit_q  <= 1'b1;
      eof_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      ones_q <= ones_d;
      stf_q  <= stf_d;
      eofc_q <= eofc_d;
      bit_q  <= bit_d;
      eof_q  <= eof_d;
    end
  end

  assign tx_bit = bit_q;
  assign tx_eof = eof_q;

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(bit_q) && $stable(eof_q)));

  // R7
  run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= RUN_W'(RUN_LEN));

  // R10
  eof_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eof_q) |-> !bit_q);

endmodule

// File: rtl/hdlc_pre_tx.sv
module hdlc_pre_tx
  import hdlc_tx_pkg::*;
#(
  parameter int REP_W   = 2,
  parameter int RUN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              cfg_pre_en,
  input  logic [BYTE_W-1:0] cfg_pre_pat,
  input  logic [REP_W-1:0]  cfg_rep_code,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_bit,
  output logic              tx_eof
);

  logic [BYTE_W-1:0] ld_byte;
  logic              ld_stuff;
  logic              ld_eof;
  logic              load;
  logic              take;
  logic              crc_init;
  logic [FCS_W-1:0]  crc;

  hdlc_tx_seq #(.REP_W(REP_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .cfg_pre_en   (cfg_pre_en),
    .cfg_pre_pat  (cfg_pre_pat),
    .cfg_rep_code (cfg_rep_code),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_last      (in_last),
    .fcs_crc      (crc),
    .ld_byte      (ld_byte),
    .ld_stuff     (ld_stuff),
    .ld_eof       (ld_eof),
    .take         (take),
    .crc_init     (crc_init)
  );

  hdlc_fcs_gen #(
    .W      (FCS_W),
    .DW     (BYTE_W),
    .POLY   (FCS_POLY_R),
    .PRESET (FCS_SEED)
  ) u_fcs (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (crc_init),
    .upd   (take),
    .din   (in_data),
    .crc   (crc)
  );

  hdlc_bit_ser #(.RUN_LEN(RUN_LEN)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .ld_byte  (ld_byte),
    .ld_stuff (ld_stuff),
    .ld_eof   (ld_eof),
    .load     (load),
    .tx_bit   (tx_bit),
    .tx_eof   (tx_eof)
  );

  assign in_ready = take;

  // R9
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

endmodule

// File: tb/hdlc_pre_tx_tb.sv
`timescale 1ns/100ps
module hdlc_pre_tx_tb;

  typedef logic [7:0] octet_q_t[$];
  typedef struct {
    logic  b;
    logic  e;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic       cfg_pre_en;
  logic [7:0] cfg_pre_pat;
  logic [1:0] cfg_rep_code;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready;
  logic       tx_bit;
  logic       tx_eof;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t exp_q[$];
  int   ones_m;
  int   hs_cnt = 0;
  bit   in_frame = 0;
  int   ph = 0;
  bit   gap_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_bit = 1'b1;
  logic prev_eof = 1'b0;
  logic en_q = 1'b0;
  logic valid_q = 1'b0;
  logic rdy_q = 1'b0;

  always #2.5 clk = ~clk;

  hdlc_pre_tx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .cfg_pre_en   (cfg_pre_en),
    .cfg_pre_pat  (cfg_pre_pat),
    .cfg_rep_code (cfg_rep_code),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_last      (in_last),
    .in_ready     (in_ready),
    .tx_bit       (tx_bit),
    .tx_eof       (tx_eof)
  );

  function automatic void chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endfunction

  function automatic void push_raw(logic [7:0] oct, bit eof_at_end, string tag);
    for (int i = 0; i < 8; i++)
      exp_q.push_back('{oct[i], (eof_at_end && i == 7), tag});
  endfunction

  // R7: model of zero insertion in payload and FCS
  function automatic void push_stuffed(logic [7:0] oct, string tag);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back('{oct[i], 1'b0, tag});
      if (oct[i]) ones_m++; else ones_m = 0;
      if (ones_m == 5) begin
        exp_q.push_back('{1'b0, 1'b0, "R7"});
        ones_m = 0;
      end
    end
  endfunction

  // R8: reference CRC, bitwise
  function automatic logic [15:0] ref_crc(octet_q_t d);
    logic [15:0] c = 16'hFFFF;
    logic        fb;
    foreach (d[k]) begin
      for (int i = 0; i < 8; i++) begin
        fb = d[k][i] ^ c[0];
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  // capture what the design saw at each rising edge
  always @(posedge clk) begin
    en_q    <= bit_en;
    valid_q <= in_valid;
    rdy_q   <= in_ready;
  end

  // monitor: compares each line bit against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (en_q) begin
        if (!in_frame) begin
          // R2: fill flags between frames
          chk(tx_bit == 1'(8'h7E >> ph), "R2 fill bit", tx_bit, 1'(8'h7E >> ph));
          chk(tx_eof == 1'b0, "R10 no eof in fill", tx_eof, 0);
          if (ph == 7) begin
            ph = 0;
            if (valid_q) in_frame = 1;  // R3 start on octet boundary
          end else ph++;
        end else if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame bits", tx_bit, 0);
          in_frame = 0;
          ph = 0;
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(tx_bit == e.b, e.tag, tx_bit, e.b);
          chk(tx_eof == e.e, "R10 eof marker", tx_eof, e.e);
          if (e.e && !valid_q) begin
            in_frame = 0;
            ph = 0;
          end
        end
        prev_bit = tx_bit;
        prev_eof = tx_eof;
      end else begin
        // R11: outputs hold with bit_en low
        chk(tx_bit == prev_bit && tx_eof == prev_eof, "R11 hold",
            {tx_bit, tx_eof}, {prev_bit, prev_eof});
      end
      if (rdy_q) hs_cnt++;
      if (gap_mode) begin
        lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bit_en = lfsr[0] | lfsr[3];
      end else begin
        bit_en = 1'b1;
      end
    end
  end

  // driver: queue the expected line bits, then hand over the bytes
  task automatic send_frame(octet_q_t d, bit want_pre, logic [7:0] pat,
                            int reps, bit hold_valid, string open_tag);
    logic [15:0] fcs;
    int          hs0;
    fcs = ~ref_crc(d);
    if (want_pre)
      for (int r = 0; r < reps; r++) push_raw(pat, 1'b0, (pat == 8'hFF) ? "R5" : "R4");
    push_raw(8'h7E, 1'b0, open_tag);
    ones_m = 0;
    foreach (d[k]) push_stuffed(d[k], "R7 payload");
    push_stuffed(fcs[7:0],  "R8 fcs low");
    push_stuffed(fcs[15:8], "R8 fcs high");
    push_raw(8'h7E, 1'b1, "R3 closing flag");
    hs0 = hs_cnt;
    foreach (d[k]) begin
      in_valid = 1'b1;
      in_data  = d[k];
      in_last  = (k == d.size() - 1);
      while (!in_ready) begin
        @(negedge clk); #1;
      end
      @(negedge clk); #1;
    end
    if (!hold_valid) begin
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
    // R9: one acceptance per payload byte
    chk(hs_cnt - hs0 == d.size(), "R9 byte acceptances", hs_cnt - hs0, d.size());
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || in_frame) begin
      @(negedge clk); #1;
    end
    repeat (40) @(negedge clk);
    #1;
  endtask

  initial begin
    octet_q_t f;
    rst_n        = 1'b0;
    bit_en       = 1'b0;
    cfg_pre_en   = 1'b0;
    cfg_pre_pat  = 8'h00;
    cfg_rep_code = 2'd0;
    in_valid     = 1'b0;
    in_data      = 8'h00;
    in_last      = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    chk(tx_bit == 1'b1, "R1 tx_bit in reset", tx_bit, 1);
    chk(tx_eof == 1'b0, "R1 tx_eof in reset", tx_eof, 0);
    chk(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    chk(tx_bit == 1'b1 && in_ready == 1'b0, "R1 after release", tx_bit, 1);
    repeat (30) @(negedge clk);
    #1;

    // plain frame, no preamble
    f = '{8'h12, 8'h34};
    send_frame(f, 1'b0, 8'h00, 0, 1'b0, "R3 opening flag");
    wait_idle();

    // one preamble, stuffing across octet boundaries
    cfg_pre_en = 1'b1; cfg_pre_pat = 8'hA5; cfg_rep_code = 2'd0;
    f = '{8'hFF, 8'hFF, 8'h7E, 8'hF8};
    send_frame(f, 1'b1, 8'hA5, 1, 1'b0, "R4 opening flag");
    wait_idle();

    // R5: eight repetitions of all ones, not stuffed
    cfg_pre_pat = 8'hFF; cfg_rep_code = 2'd3;
    f = '{8'h00};
    send_frame(f, 1'b1, 8'hFF, 8, 1'b0, "R5 opening flag");
    wait_idle();

    // R6: back-to-back frames share no fill and get no preamble
    cfg_pre_pat = 8'h3C; cfg_rep_code = 2'd1;
    f = '{8'h01, 8'h02};
    send_frame(f, 1'b1, 8'h3C, 2, 1'b1, "R4 opening flag");
    f = '{8'hF8, 8'h1F, 8'hBE};
    send_frame(f, 1'b0, 8'h3C, 0, 1'b0, "R6 opening flag");
    wait_idle();

    // R11 and R4: gapped bit enable, four repetitions
    gap_mode = 1'b1;
    cfg_pre_pat = 8'h81; cfg_rep_code = 2'd2;
    f = '{8'h55, 8'hAA, 8'hFF, 8'h3F};
    send_frame(f, 1'b1, 8'h81, 4, 1'b0, "R4 opening flag");
    wait_idle();
    gap_mode = 1'b0;

    // preamble disabled again
    cfg_pre_en = 1'b0;
    f = '{8'h7D, 8'hFE};
    send_frame(f, 1'b0, 8'h00, 0, 1'b0, "R3 opening flag");
    wait_idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule